// File: doc/BRIEF.md
# Chained Pipelined Vector Arithmetic Unit

This block performs element-wise integer arithmetic over a vector of up to `MVL` signed elements. An operation is started by a one-cycle issue pulse carrying the opcode, the active element count, a per-element enable mask and two operand-routing choices. Once started, the unit walks the element indices in ascending order, reads one element of each source per cycle from an external register file through a combinational read port, and pushes the computed value into a fixed-depth pipeline. Every element leaves the pipeline with its own valid strobe and index, so a downstream unit can use each result as soon as it appears.

Operand B may be replaced by a scalar captured at issue and reused for every element. Operand A may instead be taken from a chaining input stream: the results of an earlier, still-running operation, presented one element per strobe in index order. In that mode the sequencer advances only on cycles when the stream offers an element, which resolves a read-after-write dependency one element at a time instead of one vector at a time. Elements whose mask bit is clear still travel through the pipeline and produce a result strobe, but their write enable stays low, so the destination element is left as it was.

Top module: `vec_chain_alu`

## Requirements
- R1: With the chaining input not selected, element reads (`rd_vld`) occur on consecutive cycles starting the cycle after issue, with `rd_idx` counting 0, 1, 2, ... in order; chaining-input strobes have no effect in this mode.
- R2: The result for the element read in cycle c appears on `res_vld`/`res_idx` in cycle c + DEPTH (DEPTH = 4 by default), and in no other cycle.
- R3: The number of elements processed equals `iss_len`, clamped to `MVL` when `iss_len` exceeds it.
- R4: Bit i of `iss_mask` enables element i; for an element whose bit is clear, the result strobe is still given but `res_we` stays low.
- R5: Opcode 0 adds, 1 subtracts (A minus B), 2 is bitwise AND, 3 bitwise OR, 4 bitwise XOR; opcodes 5 to 7 give zero. Arithmetic wraps modulo 2^DW.
- R6: With `iss_bsel` high, operand B for every element is the `iss_scalar` value captured at issue, and `rd_b` is not used.
- R7: With `iss_chain` high, operand A of element i is `chn_data` in the cycle of its read, and an element is read only in a cycle where `chn_vld` is high.
- R8: `busy` rises the cycle after an accepted issue with a non-zero length, stays high up to and including the cycle of the last result strobe, and is low in the following cycle.
- R9: An issue pulse while `busy` is high is ignored: the running operation keeps its opcode, length and routing.
- R10: An issue with length zero raises neither `busy` nor any read or result strobe.
- R11: After reset, `busy`, `rd_vld`, `res_vld` and `res_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_vld | input | 1 | Issue request pulse |
| iss_op | input | 3 | Opcode (see R5) |
| iss_len | input | LW (5) | Active element count |
| iss_mask | input | MVL (16) | Per-element enable mask |
| iss_bsel | input | 1 | Take operand B from the scalar |
| iss_scalar | input | DW (32) | Scalar operand |
| iss_chain | input | 1 | Take operand A from the chaining stream |
| rd_vld | output | 1 | Element read strobe to the register file |
| rd_idx | output | IW (4) | Element index being read |
| rd_a | input | DW (32) | Source A element at `rd_idx` |
| rd_b | input | DW (32) | Source B element at `rd_idx` |
| chn_vld | input | 1 | Chaining stream element available |
| chn_data | input | DW (32) | Chaining stream element value |
| res_vld | output | 1 | Result element strobe |
| res_we | output | 1 | Destination write enable |
| res_idx | output | IW (4) | Result element index |
| res_data | output | DW (32) | Result element value |
| busy | output | 1 | Operation in progress |

## Verification
The properties assume that `rd_a` and `rd_b` answer combinationally for the index on `rd_idx`, and that the chaining stream delivers producer elements strictly in index order, one per `chn_vld` cycle; the bench models the register file as an array indexed by `rd_idx` and feeds the chaining input from an ordered source array with a per-element token counter. Issue pulses are applied on idle cycles except where a pulse during a running operation is placed on purpose. Chaining strobes arrive with a random gap rate, including while the mode is off, so stalls and ignored strobes are both covered.

// File: rtl/vca_pkg.sv
`timescale 1ns/1ps
package vca_pkg;
    localparam int OPW = 3;

    localparam logic [OPW-1:0] OP_ADD = 3'd0;
    localparam logic [OPW-1:0] OP_SUB = 3'd1;
    localparam logic [OPW-1:0] OP_AND = 3'd2;
    localparam logic [OPW-1:0] OP_OR  = 3'd3;
    localparam logic [OPW-1:0] OP_XOR = 3'd4;
endpackage

// File: rtl/vca_alu.sv
`timescale 1ns/1ps
module vca_alu #(
    parameter int DW = 32
) (
    input  logic [vca_pkg::OPW-1:0] op,
    input  logic [DW-1:0]           opa,
    input  logic [DW-1:0]           opb,
    output logic [DW-1:0]           res
);
    import vca_pkg::*;

    always_comb begin
        unique case (op)
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/vca_seq.sv
`timescale 1ns/1ps
module vca_seq #(
    parameter int MVL = 16,
    parameter int DW  = 32,
    parameter int LW  = $clog2(MVL + 1),
    parameter int IW  = $clog2(MVL)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_vld,
    input  logic [vca_pkg::OPW-1:0] iss_op,
    input  logic [LW-1:0]           iss_len,
    input  logic [MVL-1:0]          iss_mask,
    input  logic                    iss_bsel,
    input  logic [DW-1:0]           iss_scalar,
    input  logic                    iss_chain,
    input  logic                    chn_vld,
    input  logic                    pipe_busy,
    output logic                    el_vld,
    output logic [IW-1:0]           el_idx,
    output logic                    el_msk,
    output logic [vca_pkg::OPW-1:0] el_op,
    output logic                    el_bsel,
    output logic [DW-1:0]           el_scalar,
    output logic                    el_chain,
    output logic                    busy
);
    localparam logic [LW-1:0] LEN_MAX = LW'(MVL);

    typedef struct packed {
        logic                    act;
        logic [LW-1:0]           cnt;
        logic [LW-1:0]           len;
        logic [vca_pkg::OPW-1:0] op;
        logic [MVL-1:0]          msk;
        logic                    bsel;
        logic [DW-1:0]           scal;
        logic                    chain;
    } seq_t;

    seq_t s_d, s_q;
    logic fire;
    logic [LW-1:0] len_c;
    logic [LW-1:0] cnt_nx;

    assign busy = s_q.act | pipe_busy;

    always_comb begin
        s_d    = s_q;
        fire   = s_q.act & (~s_q.chain | chn_vld);
        cnt_nx = s_q.cnt + 1'b1;
        len_c  = (iss_len > LEN_MAX) ? LEN_MAX : iss_len;

        if (fire) begin
            s_d.cnt = cnt_nx;
            if (cnt_nx == s_q.len) begin
                s_d.act = 1'b0;
            end
        end

        if (iss_vld && !busy) begin
            s_d.act   = (len_c != '0);
            s_d.cnt   = '0;
            s_d.len   = len_c;
            s_d.op    = iss_op;
            s_d.msk   = iss_mask;
            s_d.bsel  = iss_bsel;
            s_d.scal  = iss_scalar;
            s_d.chain = iss_chain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign el_vld    = fire;
    assign el_idx    = s_q.cnt[IW-1:0];
    assign el_msk    = s_q.msk[el_idx];
    assign el_op     = s_q.op;
    assign el_bsel   = s_q.bsel;
    assign el_scalar = s_q.scal;
    assign el_chain  = s_q.chain;
endmodule

// File: rtl/vca_pipe.sv
`timescale 1ns/1ps
module vca_pipe #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_msk,
    input  logic [IW-1:0] in_idx,
    input  logic [DW-1:0] in_dat,
    output logic          out_vld,
    output logic          out_we,
    output logic [IW-1:0] out_idx,
    output logic [DW-1:0] out_dat,
    output logic          any_vld
);
    typedef struct packed {
        logic          vld;
        logic          msk;
        logic [IW-1:0] idx;
        logic [DW-1:0] dat;
    } stg_t;

    stg_t [DEPTH-1:0] p_d, p_q;

    always_comb begin
        p_d[0].vld = in_vld;
        p_d[0].msk = in_msk;
        p_d[0].idx = in_idx;
        p_d[0].dat = in_dat;
        for (int k = 1; k < DEPTH; k++) begin
            p_d[k] = p_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        any_vld = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            any_vld = any_vld | p_q[k].vld;
        end
    end

    assign out_vld = p_q[DEPTH-1].vld;
    assign out_we  = p_q[DEPTH-1].vld & p_q[DEPTH-1].msk;
    assign out_idx = p_q[DEPTH-1].idx;
    assign out_dat = p_q[DEPTH-1].dat;
endmodule

// File: rtl/vec_chain_alu.sv
`timescale 1ns/1ps
module vec_chain_alu #(
    parameter int MVL   = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int LW    = $clog2(MVL + 1),
    parameter int IW    = $clog2(MVL)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iss_vld,
    input  logic [vca_pkg::OPW-1:0] iss_op,
    input  logic [LW-1:0]           iss_len,
    input  logic [MVL-1:0]          iss_mask,
    input  logic                    iss_bsel,
    input  logic [DW-1:0]           iss_scalar,
    input  logic                    iss_chain,
    output logic                    rd_vld,
    output logic [IW-1:0]           rd_idx,
    input  logic [DW-1:0]           rd_a,
    input  logic [DW-1:0]           rd_b,
    input  logic                    chn_vld,
    input  logic [DW-1:0]           chn_data,
    output logic                    res_vld,
    output logic                    res_we,
    output logic [IW-1:0]           res_idx,
    output logic [DW-1:0]           res_data,
    output logic                    busy
);
    logic                    el_vld;
    logic [IW-1:0]           el_idx;
    logic                    el_msk;
    logic [vca_pkg::OPW-1:0] el_op;
    logic                    el_bsel;
    logic [DW-1:0]           el_scalar;
    logic                    el_chain;
    logic                    pipe_busy;
    logic [DW-1:0]           opa, opb, alu_res;

    vca_seq #(.MVL(MVL), .DW(DW), .LW(LW), .IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_vld    (iss_vld),
        .iss_op     (iss_op),
        .iss_len    (iss_len),
        .iss_mask   (iss_mask),
        .iss_bsel   (iss_bsel),
        .iss_scalar (iss_scalar),
        .iss_chain  (iss_chain),
        .chn_vld    (chn_vld),
        .pipe_busy  (pipe_busy),
        .el_vld     (el_vld),
        .el_idx     (el_idx),
        .el_msk     (el_msk),
        .el_op      (el_op),
        .el_bsel    (el_bsel),
        .el_scalar  (el_scalar),
        .el_chain   (el_chain),
        .busy       (busy)
    );

    assign opa = el_chain ? chn_data : rd_a;
    assign opb = el_bsel ? el_scalar : rd_b;

    vca_alu #(.DW(DW)) u_alu (
        .op  (el_op),
        .opa (opa),
        .opb (opb),
        .res (alu_res)
    );

    vca_pipe #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (el_vld),
        .in_msk  (el_msk),
        .in_idx  (el_idx),
        .in_dat  (alu_res),
        .out_vld (res_vld),
        .out_we  (res_we),
        .out_idx (res_idx),
        .out_dat (res_data),
        .any_vld (pipe_busy)
    );

    assign rd_vld = el_vld;
    assign rd_idx = el_idx;
endmodule

// File: rtl/vca_chk.sv
`timescale 1ns/1ps
module vca_chk #(
    parameter int DEPTH = 4
) (
    input logic clk,
    input logic rst_n,
    input logic iss_vld,
    input logic iss_chain,
    input logic rd_vld,
    input logic chn_vld,
    input logic res_vld,
    input logic res_we,
    input logic busy
);
    logic [DEPTH-1:0] rd_hist;
    logic             chain_md;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_hist  <= '0;
            chain_md <= 1'b0;
        end else begin
            rd_hist <= {rd_hist[DEPTH-2:0], rd_vld};
            if (iss_vld && !busy) begin
                chain_md <= iss_chain;
            end
        end
    end

    // R2
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld == rd_hist[DEPTH-1]);

    // R4
    we_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> res_vld);

    // R7
    chain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && chain_md) |-> chn_vld);

    // R8
    read_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> busy);

    // R8
    result_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> busy);

    // R10
    busy_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(iss_vld));
endmodule

bind vec_chain_alu vca_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_vld   (iss_vld),
    .iss_chain (iss_chain),
    .rd_vld    (rd_vld),
    .chn_vld   (chn_vld),
    .res_vld   (res_vld),
    .res_we    (res_we),
    .busy      (busy)
);

// File: tb/sim_vec_chain_alu.sv
`timescale 1ns/1ps
module sim_vec_chain_alu;
    localparam int MVL   = 16;
    localparam int DW    = 32;
    localparam int DEPTH = 4;
    localparam int LW    = 5;
    localparam int IW    = 4;
    localparam int QN    = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           iss_vld = 1'b0;
    logic [2:0]     iss_op = '0;
    logic [LW-1:0]  iss_len = '0;
    logic [MVL-1:0] iss_mask = '0;
    logic           iss_bsel = 1'b0;
    logic [DW-1:0]  iss_scalar = '0;
    logic           iss_chain = 1'b0;
    logic           rd_vld;
    logic [IW-1:0]  rd_idx;
    logic [DW-1:0]  rd_a, rd_b;
    logic           chn_vld = 1'b0;
    logic [DW-1:0]  chn_data = '0;
    logic           res_vld, res_we, busy;
    logic [IW-1:0]  res_idx;
    logic [DW-1:0]  res_data;

    logic [DW-1:0] va [MVL];
    logic [DW-1:0] vb [MVL];
    logic [DW-1:0] csrc [MVL];

    assign rd_a = va[rd_idx];
    assign rd_b = vb[rd_idx];

    vec_chain_alu #(.MVL(MVL), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

    int n_chk = 0, n_fail = 0, ncyc = 0;
    int rcnt = 0, tok = 0, res_cnt = 0, last_res = 0, gap = 0;
    int c_op = 0;
    logic c_chain = 1'b0, c_bsel = 1'b0;
    logic [DW-1:0]  c_scal = '0;
    logic [MVL-1:0] c_msk = '0;
    int          e_due [QN];
    logic [IW-1:0] e_idx [QN];
    logic [DW-1:0] e_dat [QN];
    logic        e_we [QN];
    int qh = 0, qt = 0;
    bit done_flag = 0;

    always @(posedge clk) ncyc++;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, ncyc);
        end
    endtask

    function automatic logic [DW-1:0] ref_op(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return '0;
        endcase
    endfunction

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: results, chaining stream, element reads
    always @(negedge clk) begin
        if (rst_n) begin
            if (qh != qt && e_due[qh % QN] == ncyc) begin
                chk(res_vld == 1'b1, "R2", "result strobe", res_vld, 1);
                chk(res_idx == e_idx[qh % QN], "R2", "result index", res_idx, e_idx[qh % QN]);
                chk(res_we == e_we[qh % QN], "R4", "write enable", res_we, e_we[qh % QN]);
                if (e_we[qh % QN])
                    chk(res_data == e_dat[qh % QN], "R5", "result data", res_data, e_dat[qh % QN]);
                res_cnt++;
                last_res = ncyc;
                qh++;
            end else if (res_vld) begin
                chk(1'b0, "R2", "unexpected result strobe", res_vld, 0);
            end
            chn_vld = ($urandom_range(99) >= gap);
            chn_data = (c_chain && tok < MVL) ? csrc[tok] : $urandom;
            #1;
            if (rd_vld) begin
                logic [DW-1:0] a, b;
                chk(rd_idx == IW'(rcnt), "R1", "read index order", rd_idx, rcnt);
                if (c_chain) chk(chn_vld == 1'b1, "R7", "read without chain element", chn_vld, 1);
                a = c_chain ? chn_data : va[rcnt % MVL];
                b = c_bsel ? c_scal : vb[rcnt % MVL];
                e_due[qt % QN] = ncyc + DEPTH;
                e_idx[qt % QN] = IW'(rcnt);
                e_dat[qt % QN] = ref_op(c_op, a, b);
                e_we[qt % QN]  = c_msk[rcnt % MVL];
                qt++;
                rcnt++;
                if (c_chain) tok++;
            end
        end
    end

    task automatic run_op(int op, int len, logic [MVL-1:0] msk, bit bsel, logic [DW-1:0] scal,
                          bit chain, int g, bit poke);
        int t0, exp_n, w;
        @(negedge clk);
        for (int i = 0; i < MVL; i++) begin
            va[i] = $urandom; vb[i] = $urandom; csrc[i] = $urandom;
        end
        if (op == 0 && len == 3) begin
            va[0] = 32'hFFFF_FFFF; vb[0] = 32'h0000_0001;   // add wrap R5
        end
        c_op = op; c_chain = chain; c_bsel = bsel; c_scal = scal; c_msk = msk; gap = g;
        rcnt = 0; tok = 0; res_cnt = 0;
        iss_op = 3'(op); iss_len = LW'(len); iss_mask = msk; iss_bsel = bsel;
        iss_scalar = scal; iss_chain = chain; iss_vld = 1'b1;
        t0 = ncyc;
        exp_n = (len > MVL) ? MVL : len;
        @(negedge clk);
        iss_vld = 1'b0;
        if (exp_n == 0) begin
            for (int k = 0; k < 6; k++) begin
                #2;
                chk(busy == 1'b0, "R10", "busy on zero length", busy, 0);
                chk(res_cnt == 0 && rcnt == 0, "R10", "strobes on zero length", res_cnt + rcnt, 0);
                @(negedge clk);
            end
            return;
        end
        if (poke) begin
            // R9: a second issue while the first runs must be ignored
            @(negedge clk);
            iss_op = 3'(op + 2); iss_len = LW'(2); iss_bsel = ~bsel; iss_chain = 1'b0;
            iss_mask = ~msk; iss_vld = 1'b1;
            @(negedge clk);
            iss_vld = 1'b0;
        end
        w = 0;
        #2;
        while (res_cnt < exp_n && w < 400) begin
            @(negedge clk); #2;
            w++;
        end
        chk(res_cnt == exp_n, "R3", "element count", res_cnt, exp_n);
        if (poke) chk(res_cnt == exp_n, "R9", "count after ignored issue", res_cnt, exp_n);
        chk(busy == 1'b1, "R8", "busy at last result", busy, 1);
        if (!chain)
            chk(last_res == t0 + exp_n + DEPTH, "R1", "last result cycle", last_res, t0 + exp_n + DEPTH);
        @(negedge clk); #2;
        chk(busy == 1'b0, "R8", "busy after last result", busy, 0);
        chk(qh == qt, "R2", "pending results", qt - qh, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 0, "R11", "busy in reset", busy, 0);
        chk(rd_vld == 0, "R11", "rd_vld in reset", rd_vld, 0);
        chk(res_vld == 0 && res_we == 0, "R11", "result strobes in reset", {res_vld, res_we}, 0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        chk(busy == 0, "R11", "busy after reset", busy, 0);

        run_op(0, 16, 16'hFFFF, 0, '0, 0, 50, 0);            // R1 R5 full add, chain strobes ignored
        run_op(0, 3, 16'hFFFF, 0, '0, 0, 20, 0);             // R5 wrap
        run_op(1, 9, 16'hFFFF, 1, 32'h0000_1234, 0, 0, 0);   // R6 scalar subtract
        run_op(2, 7, 16'hA5A5, 0, '0, 0, 30, 0);             // R4 mask
        run_op(3, 5, 16'h0000, 0, '0, 0, 30, 0);             // R4 all masked
        run_op(4, 12, 16'h7FFF, 1, 32'hDEAD_BEEF, 0, 0, 0);  // R6 xor scalar
        run_op(6, 4, 16'hFFFF, 0, '0, 0, 0, 0);              // R5 unused opcode
        run_op(0, 20, 16'hFFFF, 0, '0, 0, 0, 0);             // R3 clamp
        run_op(0, 0, 16'hFFFF, 0, '0, 0, 0, 0);              // R10
        run_op(1, 1, 16'hFFFF, 0, '0, 0, 0, 0);              // R2 single element
        run_op(0, 10, 16'hFFFF, 0, '0, 1, 60, 0);            // R7 chained with stalls
        run_op(2, 16, 16'h3C3C, 1, 32'h0F0F_F0F0, 1, 0, 0);  // R7 chained, no stalls
        run_op(0, 8, 16'hFFFF, 0, '0, 0, 0, 1);              // R9
        run_op(3, 6, 16'h00FF, 0, '0, 1, 40, 1);             // R9 in chained mode

        for (int n = 0; n < 40; n++) begin
            run_op($urandom_range(7), $urandom_range(20), 16'($urandom), $urandom_range(1),
                   $urandom, $urandom_range(1), $urandom_range(70), $urandom_range(3) == 0);
        end
        repeat (3) @(negedge clk);
        summary();
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule